// File: doc/BRIEF.md
# Logarithmic Rotate-or-Shift Unit

This block moves a 40-bit word to the left by any amount from 0 to 63 in one pass. It can rotate the word cyclically or shift it with zero fill. The word passes through six cascaded layers of two-input selectors. The layer with weight 2^i moves the word by 2^i places when bit i of the count is set, and passes it through untouched when that bit is clear. Every count passes through all six layers, so the combinational depth is the same for every amount.

A request carries the word, a 6-bit count and a mode bit. It enters over a valid/ready stream. The result leaves on a second valid/ready stream from a single output register. A request is accepted in any cycle where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty, or when its current result is being taken in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held and no new request is taken. The mode bit is plain control and travels with its request.

In rotate mode, bits that leave the top end re-enter at the bottom, so a count k gives a rotation by k mod 40. In shift mode, the wrap-around paths are replaced by zeros, so counts of 40 to 63 clear the word.

Top module: `rot_shift_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is 0.
- R2: A count of 0 returns the accepted word unchanged, in either mode.
- R3: With `in_cyclic` = 1, a count k returns the word rotated left by k mod 40. Output bit j equals input bit (j − (k mod 40)) mod 40.
- R4: With `in_cyclic` = 0 and k < 40, output bit j equals input bit j − k for j ≥ k, and is 0 for j < k.
- R5: With `in_cyclic` = 0 and k ≥ 40, the output word is all zeros.
- R6: The result of a request accepted at clock edge t is presented with `out_valid` = 1 right after edge t.
- R7: While `out_valid` = 1 and `out_ready` = 0, `out_data` and `out_valid` hold their values and `in_ready` is 0.
- R8: Results leave in the order their requests were accepted. None is lost or duplicated under any pattern of back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_data | input | 40 | Word to move |
| in_count | input | 6 | Shift or rotate amount, 0 to 63 |
| in_cyclic | input | 1 | 1 = rotate, 0 = shift with zero fill |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 40 | Moved word |

## Verification
Each result is due at the clock edge that accepts its request, with exactly one register on the path. The bench pushes its reference value into a queue at the moment the handshake is certain. It then compares the head of the queue against `out_data` at the first falling edge where `out_valid` and `out_ready` are both high. While the consumer stalls, the bench samples the held output at each falling edge and compares it with the value it held before, and checks that `in_ready` is low. All 64 counts are run in both modes, with random words and a few fixed bit patterns.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
  localparam int RSU_WORD_W  = 40;
  localparam int RSU_COUNT_W = 6;
endpackage

// File: rtl/rsu_mux2.sv
module rsu_mux2 #(
  parameter int W = 40
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel,
  output logic [W-1:0] y
);
  // sel = 1 picks a, sel = 0 picks b
  assign y = sel ? a : b;
endmodule

// File: rtl/rsu_layer.sv
module rsu_layer #(
  parameter int W     = 40,
  parameter int SHIFT = 1
) (
  input  logic [W-1:0] din,
  input  logic         sel,
  input  logic         cyclic,
  output logic [W-1:0] dout
);
  localparam int ROT = SHIFT % W;

  logic [W-1:0] rot_v;
  logic [W-1:0] shf_v;
  logic [W-1:0] moved;

  for (genvar j = 0; j < W; j++) begin : g_bit
    if (j >= ROT) begin : g_rin
      assign rot_v[j] = din[j-ROT];
    end else begin : g_rwrap
      assign rot_v[j] = din[j-ROT+W];
    end
    if (SHIFT < W && j >= SHIFT) begin : g_sin
      assign shf_v[j] = din[j-SHIFT];
    end else begin : g_sfill
      assign shf_v[j] = 1'b0;
    end
  end

  assign moved = cyclic ? rot_v : shf_v;

  rsu_mux2 #(.W(W)) u_sel (
    .a  (moved),
    .b  (din),
    .sel(sel),
    .y  (dout)
  );
endmodule

// File: rtl/rsu_core.sv
module rsu_core #(
  parameter int W  = 40,
  parameter int CW = 6
) (
  input  logic [W-1:0]  din,
  input  logic [CW-1:0] count,
  input  logic          cyclic,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stage [CW+1];

  assign stage[0] = din;

  for (genvar i = 0; i < CW; i++) begin : g_layer
    rsu_layer #(.W(W), .SHIFT(1 << i)) u_layer (
      .din   (stage[i]),
      .sel   (count[i]),
      .cyclic(cyclic),
      .dout  (stage[i+1])
    );
  end

  assign dout = stage[CW];
endmodule

// File: rtl/rot_shift_unit.sv
module rot_shift_unit #(
  parameter int DATA_W = rsu_pkg::RSU_WORD_W,
  parameter int CNT_W  = rsu_pkg::RSU_COUNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CNT_W-1:0]  in_count,
  input  logic              in_cyclic,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic [DATA_W-1:0] moved;
  logic              take;

  rsu_core #(.W(DATA_W), .CW(CNT_W)) u_core (
    .din   (in_data),
    .count (in_count),
    .cyclic(in_cyclic),
    .dout  (moved)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take)     out_data  <= moved;
    end
  end
endmodule

// File: rtl/rot_shift_chk.sv
module rot_shift_chk #(
  parameter int DATA_W = 40,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic [CNT_W-1:0]  in_count,
  input logic              in_cyclic,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);
  AST_ZERO_COUNT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_count == '0) |=> out_data == $past(in_data)); // R2

  AST_ROTATE_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_cyclic) |=> $countones(out_data) == $countones($past(in_data))); // R3

  AST_SHIFT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_cyclic && in_count != '0) |=> out_data[0] == 1'b0); // R4

  AST_SHIFT_FAR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_cyclic && int'(in_count) >= DATA_W) |=> out_data == '0); // R5

  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7

  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R7
endmodule

bind rot_shift_unit rot_shift_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_data  (in_data),
  .in_count (in_count),
  .in_cyclic(in_cyclic),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data)
);

// File: tb/sim_rot_shift_unit.sv
module sim_rot_shift_unit;
  localparam int W  = 40;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_data = '0;
  logic [CW-1:0] in_count = '0;
  logic          in_cyclic = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [W-1:0]  out_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  bit stall_mode = 1'b0;

  typedef struct {
    logic [W-1:0] val;
    int           req;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  rot_shift_unit #(.DATA_W(W), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_count(in_count), .in_cyclic(in_cyclic),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [W-1:0] ref_move(logic [W-1:0] d, int k, bit cyc);
    logic [W-1:0] r;
    int amt;
    if (cyc) begin
      amt = k % W;
      r = (d << amt) | (d >> (W - amt));
      if (amt == 0) r = d;
    end else if (k >= W) begin
      r = '0;
    end else begin
      r = d << k;
    end
    return r;
  endfunction

  function automatic int req_of(int k, bit cyc);
    if (k == 0) return 2;
    if (cyc) return 3;
    if (k >= W) return 5;
    return 4;
  endfunction

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [W-1:0] d, int k, bit cyc);
    bit sent = 1'b0;
    while (!sent) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_data   = d;
      in_count  = CW'(k);
      in_cyclic = cyc;
      #1;
      if (in_ready) begin
        sb.push_back('{ref_move(d, k, cyc), req_of(k, cyc)});
        sent = 1'b1;
        @(posedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: chooses back-pressure, compares results, checks stalls
  initial begin
    logic [W-1:0] held;
    bit           was_stalled;
    exp_t         e;
    was_stalled = 1'b0;
    held = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        out_ready = stall_mode ? ($urandom_range(0, 2) == 0) : 1'b1;
        #1;
        if (was_stalled) begin
          // R7: stalled result must stay put
          check(out_valid === 1'b1 && out_data === held, "R7", out_data, held);
        end
        if (out_valid && !out_ready) begin
          check(in_ready === 1'b0, "R7", {39'b0, in_ready}, '0);
          was_stalled = 1'b1;
          held = out_data;
        end else begin
          was_stalled = 1'b0;
        end
        if (out_valid && out_ready) begin
          if (sb.size() == 0) begin
            check(1'b0, "R8", out_data, '0);
          end else begin
            e = sb.pop_front();
            check(out_data === e.val, $sformatf("R%0d", e.req), out_data, e.val);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    repeat (3) @(negedge clk);
    // R1: idle during reset
    check(out_valid === 1'b0, "R1", {39'b0, out_valid}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid === 1'b0 && in_ready === 1'b1, "R1", {39'b0, out_valid}, '0);

    // R6: one request, result right after acceptance edge
    @(negedge clk);
    in_valid = 1'b1; in_data = 40'h00_0000_0001; in_count = 6'd5; in_cyclic = 1'b0;
    sb.push_back('{ref_move(40'h1, 5, 1'b0), 4});
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, "R6", {39'b0, out_valid}, 40'h1);
    check(out_data === 40'h20, "R6", out_data, 40'h20);
    repeat (2) @(negedge clk);

    // exhaustive counts in both modes on random words, free-flowing
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < 64; k++) begin
        d = {$urandom, $urandom};
        send(d, k, c[0]);
      end
    end
    // fixed patterns: top bit, all ones, alternating
    send(40'h80_0000_0000, 1, 1'b1);   // R3 wrap to bit 0
    send(40'h80_0000_0000, 1, 1'b0);   // R4 drops out
    send('1, 39, 1'b0);                // R4 single survivor
    send('1, 40, 1'b0);                // R5
    send('1, 63, 1'b0);                // R5
    send(40'hAA_AAAA_AAAA, 41, 1'b1);  // R3 k mod 40 = 1
    send(40'h12_3456_789A, 0, 1'b1);   // R2
    send(40'h12_3456_789A, 0, 1'b0);   // R2

    // R7 and R8 under random back-pressure
    stall_mode = 1'b1;
    for (int n = 0; n < 150; n++) begin
      d = {$urandom, $urandom};
      send(d, $urandom_range(0, 63), $urandom_range(0, 1) == 1);
    end
    repeat (40) @(negedge clk);
    stall_mode = 1'b0;
    repeat (10) @(negedge clk);
    // R8: nothing left behind
    check(sb.size() == 0, "R8", W'(sb.size()), '0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule